// File: doc/BRIEF.md
# IDE Bus-Master DMA Register Block

This block holds the bus-master control state for a two-channel IDE controller. Each channel has three registers on a byte-addressed register bus: a command byte, a status byte and a 32-bit pointer to a descriptor table. Software writes these registers. When software sets or clears the run bit, the block sends a start or an abort pulse, with the table base, to a DMA engine outside the block. When that engine reports that a channel has finished, the block updates the channel's run, active and interrupt bits.

The same block keeps a per-channel copy of the device-select bit. It takes this bit from writes to the drive-select register, and the controller uses the copy to pick which disk a transfer goes to. Reads are combinational: a 32-bit little-endian window starts at the read address.

Top module: `busmaster_regs`

## Requirements
- R1: After reset, both status bytes read 0x60 and every other register byte reads 0x00. `dev_sel`, `dma_start`, `dma_abort` and `size_err` are all 0.
- R2: Register map. For channel c, the base is 8*c. The command byte is at base+0, the status byte at base+2, and the pointer at base+4..7. Bytes base+1 and base+3 read 0. `rd_data` byte k is the register byte at `rd_addr`+k.
- R3: A command write that takes the run bit (bit 0) from 0 to 1 sets the status active bit (bit 0). In the cycle after the write, `dma_start[c]` is high for exactly one cycle and `dma_base` holds that channel's pointer.
- R4: A command write that takes the run bit from 1 to 0 clears the active bit. In the cycle after the write, `dma_abort[c]` is high for one cycle.
- R5: While the run bit is 1 before a write, a command write leaves the direction bit (bit 3) unchanged. When the run bit is 0, the direction bit takes the written value.
- R6: Software writes never change the status active bit.
- R7: Writing 1 to status bit 2 (interrupt) clears it, and writing 0 leaves it unchanged. Status bits 6:5 (drive DMA-capable) store the written value. All other status bits read 0.
- R8: A pointer write must be 32 bits wide (size code 2) at base+4. The low two bits of the pointer are stored as 0.
- R9: A register write is legal only in these cases: a byte (size code 0) at a command or status offset, or a word at a pointer offset. Any other enabled write changes no register and pulses `size_err` in the next cycle.
- R10: A pulse on `dma_done[c]` clears channel c's run and active bits and sets its interrupt bit.
- R11: When `io_en` is 0, all writes are ignored, including drive-select writes. When `bm_en` is 0, register writes are ignored but drive-select writes still take effect. Ignored writes do not raise `size_err`.
- R12: A drive-select write to channel `sel_chan` copies `sel_data` bit 4 into `dev_sel[sel_chan]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_en | input | 1 | I/O decode enable |
| bm_en | input | 1 | Bus-master enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write byte address |
| wr_size | input | 2 | Write size: 0 byte, 1 half, 2 word |
| wr_data | input | 32 | Write data, little-endian |
| rd_addr | input | 4 | Read byte address |
| rd_data | output | 32 | Read data window |
| sel_wr | input | 1 | Drive-select register write strobe |
| sel_chan | input | 1 | Channel of the drive-select write |
| sel_data | input | 8 | Drive-select write data |
| dev_sel | output | 2 | Per-channel device-select copy |
| dma_done | input | 2 | Per-channel completion pulse |
| dma_start | output | 2 | Per-channel start pulse |
| dma_abort | output | 2 | Per-channel abort pulse |
| dma_base | output | 32 | Descriptor table base sent with a start |
| size_err | output | 1 | Illegal-size write pulse |

## Verification
The bench drives command writes in several patterns: a direction-only write while idle, a rising run bit, a write that tries to change direction while running, a falling run bit, and a write after the channel has stopped. These patterns separate edge detection from level sensing and show whether the direction lock depends on the old run bit or on the written one. Status writes of all ones, all zeros and the capable pattern show the read-only active bit apart from the write-one-to-clear interrupt bit. Completion pulses are applied in both orders against starts. Misaligned and wrong-size writes are sent to every register kind, with each enable gated off in turn.

// File: rtl/bmdma_pkg.sv
// Package: shared constants for the bus-master register block.
// Assumes: an 8-byte register window per channel, with command, status and pointer at fixed offsets.
package bmdma_pkg;
    localparam int PTR_W     = 32;
    localparam int CH_SPAN   = 8;
    localparam int OFF_CMD   = 0;
    localparam int OFF_STS   = 2;
    localparam int OFF_PTR   = 4;
    localparam int CMD_RUN   = 0;
    localparam int CMD_DIR   = 3;
    localparam int STS_ACT   = 0;
    localparam int STS_IRQ   = 2;
    localparam int STS_CAP0  = 5;
    localparam int STS_CAP1  = 6;
    localparam int SEL_DEV   = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSV  = 2'd3
    } acc_size_e;
endpackage

// File: rtl/bmdma_decode.sv
// Module: write decoder. It turns an enabled bus write into a per-channel strobe
// for command, status or pointer, or into an illegal-access flag.
// Assumes: the caller has already gated wr_en with the enables it wants.
module bmdma_decode #(
    parameter int NCH = 2,
    parameter int AW  = $clog2(NCH * bmdma_pkg::CH_SPAN)
) (
    input  logic            acc,
    input  logic [AW-1:0]   addr,
    input  logic [1:0]      size,
    output logic [NCH-1:0]  wr_cmd,
    output logic [NCH-1:0]  wr_sts,
    output logic [NCH-1:0]  wr_ptr,
    output logic            illegal
);
    import bmdma_pkg::*;

    localparam int CHW = (AW > 3) ? AW - 3 : 1;

    logic [2:0] off;
    logic       hit_cmd, hit_sts, hit_ptr, legal;

    // classify the offset inside the channel window together with the size
    always_comb begin
        off     = addr[2:0];
        hit_cmd = (off == 3'(OFF_CMD)) && (size == SZ_BYTE);
        hit_sts = (off == 3'(OFF_STS)) && (size == SZ_BYTE);
        hit_ptr = (off == 3'(OFF_PTR)) && (size == SZ_WORD);
        legal   = hit_cmd || hit_sts || hit_ptr;
        illegal = acc && !legal;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        // steer the strobe to the channel that owns the address
        always_comb begin
            sel       = acc && (addr[AW-1:3] == CHW'(c));
            wr_cmd[c] = sel && hit_cmd;
            wr_sts[c] = sel && hit_sts;
            wr_ptr[c] = sel && hit_ptr;
        end
    end
endmodule

// File: rtl/bmdma_channel.sv
// Module: the register set of one bus-master channel. It holds the command byte,
// the status byte and the table pointer, and it detects edges of the run bit.
// Assumes: at most one of wr_cmd/wr_sts/wr_ptr is high in a cycle. A completion
// pulse overrides a software write in the same cycle.
module bmdma_channel (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_cmd,
    input  logic        wr_sts,
    input  logic        wr_ptr,
    input  logic [31:0] wdata,
    input  logic        done,
    output logic [7:0]  cmd_o,
    output logic [7:0]  sts_o,
    output logic [31:0] ptr_o,
    output logic        start_o,
    output logic        abort_o
);
    import bmdma_pkg::*;

    logic       run_q, dir_q, act_q, irq_q, start_q, abort_q;
    logic [1:0] cap_q;
    logic [31:0] ptr_q;
    logic       rise, fall;
    logic       unused_wbits;

    assign unused_wbits = ^{wdata[7], wdata[4], wdata[1]};

    // edges of the run bit as seen by a command write
    always_comb begin
        rise = wr_cmd && wdata[CMD_RUN] && !run_q;
        fall = wr_cmd && !wdata[CMD_RUN] && run_q;
    end

    // register update: software write first, then completion wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            dir_q   <= 1'b0;
            act_q   <= 1'b0;
            irq_q   <= 1'b0;
            cap_q   <= 2'b11;
            ptr_q   <= '0;
            start_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            start_q <= rise;
            abort_q <= fall;
            if (wr_cmd) begin
                run_q <= wdata[CMD_RUN];
                if (!run_q) dir_q <= wdata[CMD_DIR];
                if (rise) act_q <= 1'b1;
                if (fall) act_q <= 1'b0;
            end
            if (wr_sts) begin
                cap_q <= wdata[STS_CAP1:STS_CAP0];
                if (wdata[STS_IRQ]) irq_q <= 1'b0;
            end
            if (wr_ptr) ptr_q <= {wdata[31:2], 2'b00};
            if (done) begin
                run_q <= 1'b0;
                act_q <= 1'b0;
                irq_q <= 1'b1;
            end
        end
    end

    // assemble the readable bytes
    always_comb begin
        cmd_o = '0;
        cmd_o[CMD_RUN] = run_q;
        cmd_o[CMD_DIR] = dir_q;
        sts_o = '0;
        sts_o[STS_ACT] = act_q;
        sts_o[STS_IRQ] = irq_q;
        sts_o[STS_CAP1:STS_CAP0] = cap_q;
        ptr_o   = ptr_q;
        start_o = start_q;
        abort_o = abort_q;
    end

    AST_DIR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && $past(run_q) |-> $stable(dir_q)); // R5
    AST_ACT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sts && !wr_cmd && !done |=> $stable(act_q)); // R6
    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> act_q || $past(done)); // R3
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |-> !act_q); // R4
    AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq_q && !act_q && !run_q); // R10
endmodule

// File: rtl/busmaster_regs.sv
// Module: two-channel bus-master register block. It decodes writes, holds the
// channel registers, sends start/abort pulses with the table base, and keeps a
// copy of the device-select bit for each channel.
// Assumes: one register write per cycle. Reads are combinational and wrap inside
// the register window.
module busmaster_regs #(
    parameter int NCH = 2,
    parameter int AW  = $clog2(NCH * bmdma_pkg::CH_SPAN),
    parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            io_en,
    input  logic            bm_en,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [1:0]      wr_size,
    input  logic [31:0]     wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [31:0]     rd_data,
    input  logic            sel_wr,
    input  logic [CW-1:0]   sel_chan,
    input  logic [7:0]      sel_data,
    output logic [NCH-1:0]  dev_sel,
    input  logic [NCH-1:0]  dma_done,
    output logic [NCH-1:0]  dma_start,
    output logic [NCH-1:0]  dma_abort,
    output logic [31:0]     dma_base,
    output logic            size_err
);
    import bmdma_pkg::*;

    localparam int NBYTES = NCH * CH_SPAN;

    logic                  acc, illegal, err_q;
    logic [NCH-1:0]        wr_cmd, wr_sts, wr_ptr;
    logic [NCH-1:0][7:0]   cmd_w, sts_w;
    logic [NCH-1:0][31:0]  ptr_w;
    logic [7:0]            regb [NBYTES];
    logic [NCH-1:0]        dev_q;
    logic                  unused_sel;

    assign unused_sel = ^{sel_data[7:5], sel_data[3:0]};

    // a register write counts only with both enables on
    always_comb acc = wr_en && io_en && bm_en;

    bmdma_decode #(.NCH(NCH), .AW(AW)) i_dec (
        .acc     (acc),
        .addr    (wr_addr),
        .size    (wr_size),
        .wr_cmd  (wr_cmd),
        .wr_sts  (wr_sts),
        .wr_ptr  (wr_ptr),
        .illegal (illegal)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        bmdma_channel i_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_cmd  (wr_cmd[c]),
            .wr_sts  (wr_sts[c]),
            .wr_ptr  (wr_ptr[c]),
            .wdata   (wr_data),
            .done    (dma_done[c]),
            .cmd_o   (cmd_w[c]),
            .sts_o   (sts_w[c]),
            .ptr_o   (ptr_w[c]),
            .start_o (dma_start[c]),
            .abort_o (dma_abort[c])
        );

        // device-select copy; gated only by I/O decode
        always_ff @(posedge clk) begin
            if (!rst_n) dev_q[c] <= 1'b0;
            else if (sel_wr && io_en && (sel_chan == CW'(c))) dev_q[c] <= sel_data[SEL_DEV];
        end
    end

    // error pulse for an enabled write of the wrong size or offset
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= illegal;
    end

    // flatten the channel registers into the byte map
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            regb[c*CH_SPAN + OFF_CMD]     = cmd_w[c];
            regb[c*CH_SPAN + OFF_CMD + 1] = 8'h00;
            regb[c*CH_SPAN + OFF_STS]     = sts_w[c];
            regb[c*CH_SPAN + OFF_STS + 1] = 8'h00;
            for (int b = 0; b < 4; b++)
                regb[c*CH_SPAN + OFF_PTR + b] = ptr_w[c][8*b +: 8];
        end
    end

    // little-endian read window starting at rd_addr
    always_comb begin
        for (int k = 0; k < 4; k++)
            rd_data[8*k +: 8] = regb[rd_addr + AW'(k)];
    end

    // table base of the channel that is starting
    always_comb begin
        dma_base = '0;
        for (int c = 0; c < NCH; c++)
            if (dma_start[c]) dma_base = ptr_w[c];
    end

    assign dev_sel  = dev_q;
    assign size_err = err_q;

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> (dma_start == '0) && (dma_abort == '0)); // R9
    AST_ERR_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> $stable(ptr_w)); // R9
    AST_SEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !io_en && sel_wr |=> $stable(dev_sel)); // R11
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_start, dma_abort})); // R3
endmodule

// File: tb/test_busmaster_regs.sv
module test_busmaster_regs;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_en, bm_en, wr_en, sel_wr;
    logic [3:0]  wr_addr, rd_addr;
    logic [1:0]  wr_size;
    logic [31:0] wr_data, rd_data, dma_base;
    logic [0:0]  sel_chan;
    logic [7:0]  sel_data;
    logic [1:0]  dev_sel, dma_done, dma_start, dma_abort;
    logic        size_err;
    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    busmaster_regs i_busmaster_regs (
        .clk(clk), .rst_n(rst_n), .io_en(io_en), .bm_en(bm_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .sel_wr(sel_wr), .sel_chan(sel_chan), .sel_data(sel_data), .dev_sel(dev_sel),
        .dma_done(dma_done), .dma_start(dma_start), .dma_abort(dma_abort),
        .dma_base(dma_base), .size_err(size_err)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  wa;
        logic [1:0]  ws;
        logic [31:0] wd;
        logic [3:0]  ra;
        logic [31:0] exp;
        logic [31:0] msk;
        logic [3:0]  rq;
    } vec_t;

    localparam vec_t TBL [15] = '{
        '{1'b1, 4'd4,  2'd2, 32'h12345677, 4'd4,  32'h12345674, 32'hFFFFFFFF, 4'd8}, // R8
        '{1'b1, 4'd12, 2'd2, 32'hCAFEBABF, 4'd12, 32'hCAFEBABC, 32'hFFFFFFFF, 4'd8}, // R8
        '{1'b1, 4'd2,  2'd0, 32'h000000FF, 4'd2,  32'h00000060, 32'h000000FF, 4'd6}, // R6
        '{1'b1, 4'd2,  2'd0, 32'h00000000, 4'd2,  32'h00000000, 32'h000000FF, 4'd7}, // R7
        '{1'b1, 4'd2,  2'd0, 32'h00000060, 4'd2,  32'h00000060, 32'h000000FF, 4'd7}, // R7
        '{1'b1, 4'd0,  2'd0, 32'h00000008, 4'd0,  32'h00000008, 32'h000000FF, 4'd2}, // R2
        '{1'b1, 4'd0,  2'd0, 32'h00000009, 4'd0,  32'h00000009, 32'h000000FF, 4'd3}, // R3
        '{1'b0, 4'd0,  2'd0, 32'h00000000, 4'd2,  32'h00000061, 32'h000000FF, 4'd3}, // R3
        '{1'b1, 4'd0,  2'd0, 32'h00000001, 4'd0,  32'h00000009, 32'h000000FF, 4'd5}, // R5
        '{1'b1, 4'd2,  2'd0, 32'h00000060, 4'd2,  32'h00000061, 32'h000000FF, 4'd6}, // R6
        '{1'b1, 4'd0,  2'd0, 32'h00000000, 4'd0,  32'h00000008, 32'h000000FF, 4'd5}, // R5
        '{1'b0, 4'd0,  2'd0, 32'h00000000, 4'd2,  32'h00000060, 32'h000000FF, 4'd4}, // R4
        '{1'b1, 4'd0,  2'd0, 32'h00000000, 4'd0,  32'h00000000, 32'h000000FF, 4'd5}, // R5
        '{1'b0, 4'd0,  2'd0, 32'h00000000, 4'd0,  32'h00600000, 32'hFFFFFFFF, 4'd2}, // R2
        '{1'b0, 4'd0,  2'd0, 32'h00000000, 4'd8,  32'h00600000, 32'hFFFFFFFF, 4'd2}  // R2
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge with results registered
    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_size = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sel(input logic c, input logic [7:0] d);
        sel_wr = 1'b1; sel_chan = c; sel_data = d;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; io_en = 1'b1; bm_en = 1'b1; wr_en = 1'b0; sel_wr = 1'b0;
        wr_addr = '0; wr_size = '0; wr_data = '0; rd_addr = '0;
        sel_chan = '0; sel_data = '0; dma_done = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd2, v);  chk("R1 sts0", {24'h0, v[7:0]}, 32'h60);
        rd(4'd10, v); chk("R1 sts1", {24'h0, v[7:0]}, 32'h60);
        rd(4'd4, v);  chk("R1 ptr0", v, 32'h0);
        rd(4'd0, v);  chk("R1 cmd0 window", v, 32'h00600000);
        chk("R1 outputs", {26'h0, dev_sel, dma_start, size_err, |dma_abort}, 32'h0);

        // table walk
        for (int i = 0; i < 15; i++) begin
            if (TBL[i].wr) wr(TBL[i].wa, TBL[i].ws, TBL[i].wd);
            rd(TBL[i].ra, v);
            chk($sformatf("R%0d vec%0d", TBL[i].rq, i), v & TBL[i].msk, TBL[i].exp & TBL[i].msk);
        end

        // R3 start pulse timing and base, channel 0
        wr(4'd0, 2'd0, 32'h01);
        chk("R3 start0 pulse", {30'h0, dma_start}, 32'h1);
        chk("R3 start0 base", dma_base, 32'h12345674);
        @(negedge clk);
        chk("R3 start0 one cycle", {30'h0, dma_start}, 32'h0);
        // R4 abort pulse
        wr(4'd0, 2'd0, 32'h00);
        chk("R4 abort0 pulse", {30'h0, dma_abort, dma_start}, 32'h4);
        @(negedge clk);
        chk("R4 abort0 one cycle", {30'h0, dma_abort}, 32'h0);

        // R3 channel 1 start
        wr(4'd8, 2'd0, 32'h01);
        chk("R3 start1 pulse", {30'h0, dma_start}, 32'h2);
        chk("R3 start1 base", dma_base, 32'hCAFEBABC);
        rd(4'd10, v); chk("R3 sts1 active", {24'h0, v[7:0]}, 32'h61);

        // R10 completion on channel 1
        dma_done = 2'b10;
        @(negedge clk);
        dma_done = 2'b00;
        rd(4'd10, v); chk("R10 sts1 after done", {24'h0, v[7:0]}, 32'h64);
        rd(4'd8, v);  chk("R10 cmd1 after done", {24'h0, v[7:0]}, 32'h00);
        rd(4'd2, v);  chk("R10 sts0 untouched", {24'h0, v[7:0]}, 32'h60);

        // R7 write-one-to-clear of interrupt
        wr(4'd10, 2'd0, 32'h60);
        rd(4'd10, v); chk("R7 irq kept on 0", {24'h0, v[7:0]}, 32'h64);
        wr(4'd10, 2'd0, 32'h64);
        rd(4'd10, v); chk("R7 irq cleared on 1", {24'h0, v[7:0]}, 32'h60);

        // R9 illegal sizes and offsets
        wr(4'd4, 2'd0, 32'h000000FF);
        chk("R9 byte to ptr err", {31'h0, size_err}, 32'h1);
        rd(4'd4, v); chk("R9 ptr held", v, 32'h12345674);
        wr(4'd0, 2'd2, 32'h00000009);
        chk("R9 word to cmd err", {31'h0, size_err}, 32'h1);
        chk("R9 no start", {30'h0, dma_start}, 32'h0);
        rd(4'd0, v); chk("R9 cmd held", {24'h0, v[7:0]}, 32'h00);
        wr(4'd2, 2'd1, 32'h00000004);
        chk("R9 half to sts err", {31'h0, size_err}, 32'h1);
        wr(4'd1, 2'd0, 32'h000000AA);
        chk("R9 pad err", {31'h0, size_err}, 32'h1);
        rd(4'd0, v); chk("R9 pad reads zero", v, 32'h00600000);
        @(negedge clk);
        chk("R9 err one cycle", {31'h0, size_err}, 32'h0);

        // R11 enables gate writes
        bm_en = 1'b0;
        wr(4'd4, 2'd2, 32'h0);
        chk("R11 bm off no err", {31'h0, size_err}, 32'h0);
        rd(4'd4, v); chk("R11 bm off ptr held", v, 32'h12345674);
        wr(4'd0, 2'd0, 32'h01);
        chk("R11 bm off no start", {30'h0, dma_start}, 32'h0);
        sel(1'b0, 8'h10);
        chk("R12 sel ch0 with bm off", {30'h0, dev_sel}, 32'h1);
        io_en = 1'b0; bm_en = 1'b1;
        sel(1'b1, 8'h10);
        chk("R11 io off sel ignored", {30'h0, dev_sel}, 32'h1);
        wr(4'd12, 2'd2, 32'h0);
        rd(4'd12, v); chk("R11 io off ptr held", v, 32'hCAFEBABC);
        io_en = 1'b1;

        // R12 shadow per channel, bit 4 only
        sel(1'b1, 8'hEF);
        chk("R12 sel ch1 bit4 clear", {30'h0, dev_sel}, 32'h1);
        sel(1'b1, 8'h10);
        chk("R12 sel ch1 set", {30'h0, dev_sel}, 32'h3);
        sel(1'b0, 8'h00);
        chk("R12 sel ch0 clear", {30'h0, dev_sel}, 32'h2);

        // R1 reset again after activity
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(4'd10, v); chk("R1 sts1 after reset", {24'h0, v[7:0]}, 32'h60);
        rd(4'd12, v); chk("R1 ptr1 after reset", v, 32'h0);
        chk("R1 sel after reset", {30'h0, dev_sel}, 32'h0);

        finish_run();
    end
endmodule